// File: doc/BRIEF.md
# Daisy-Chained Vectored Interrupt Controller

This block is the interrupt front end of a four-channel counter/timer. Each channel's counter logic hands it a one-cycle zero-count pulse; if that channel's interrupt enable is set, the block records a pending request and, when the priority chain allows, raises an active-high interrupt line to the CPU. The block sits on a priority daisy chain: it takes an enable from the device upstream and passes it downstream only while none of its own sources is pending, requested or in service.

When the CPU acknowledges (both `ack_m1` and `ack_iorq` high), the winning source places its 8-bit vector on `vec_o` with `vec_vld` high for that cycle and enters service. Vectors come from one shared base, written through a small register port, plus twice the source index. A return-from-interrupt strobe ends service of the highest-priority source in service and goes no further, so nested handlers unwind in order.

Top module: `daisy_irq_ctrl`

## Requirements
- R1: A write with `wr_sel` = 0 and `wr_data[0]` = 0 sets the base; afterwards the vector of source i is `(wr_data & 8'hF8) + 2*i`.
- R2: A write with `wr_sel` of 1 to 3, or with `wr_data[0]` = 1, leaves every source's vector unchanged.
- R3: A `zero_evt[i]` pulse with `irq_en[i]` = 1 marks source i pending at that clock edge; with `irq_en[i]` = 0 the pulse has no effect at all.
- R4: A pending source whose chain enable is high becomes requested at the next edge; `int_o` is high exactly while any source is requested, so it rises after the second edge following the zero-count pulse.
- R5: In a cycle with `ack_m1` and `ack_iorq` both high and a requested source whose chain enable is high, `vec_vld` is 1 and `vec_o` holds that source's vector in that same cycle; at the next edge the source is in service and, if no other source is requested, `int_o` falls.
- R6: Source 0 has the highest priority and source 3 the lowest. The chain enable seen by source i is `iei` gated low by any lower-index source that is not idle, and `ieo` is `iei` gated by all four sources.
- R7: On `reti`, only the lowest-index source in service leaves service, even if a higher-priority source is pending or requested; one strobe clears at most one source.
- R8: After reset all sources are idle, every vector is `2*i`, `int_o` and `vec_vld` are 0 and `ieo` follows `iei`.
- R9: `vec_o` is zero whenever `vec_vld` is 0, and `vec_vld` is never high outside an acknowledge cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| zero_evt | input | 4 | Per-source zero-count pulse from counter logic |
| irq_en | input | 4 | Per-source interrupt enable |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Source addressed by the write |
| wr_data | input | 8 | Write data |
| iei | input | 1 | Priority enable from upstream device |
| ieo | output | 1 | Priority enable to downstream device |
| int_o | output | 1 | Active-high interrupt request |
| ack_m1 | input | 1 | Acknowledge qualifier, fetch phase |
| ack_iorq | input | 1 | Acknowledge qualifier, I/O phase |
| reti | input | 1 | Return-from-interrupt strobe |
| vec_o | output | 8 | Interrupt vector, zero when not valid |
| vec_vld | output | 1 | Vector valid during acknowledge |

## Verification
Acknowledge and return-from-interrupt can arrive in the same cycle: one source entering service while a lower-priority one leaves it. The bench builds this with source 2 in service and source 0 requested, strobes both at once, and expects source 0's vector on the bus, source 2 released, and exactly one further `reti` to reopen `ieo`. Simultaneous zero-count pulses on two sources are also provoked, and the order of the vectors returned by successive acknowledges must follow source index.

// File: rtl/daisy_irq_ctrl.sv
module daisy_irq_ctrl #(
  parameter int NSRC = 4,
  parameter int VW   = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] zero_evt,
  input  logic [NSRC-1:0] irq_en,
  input  logic            wr_en,
  input  logic [$clog2(NSRC)-1:0] wr_sel,
  input  logic [VW-1:0]   wr_data,
  input  logic            iei,
  output logic            ieo,
  output logic            int_o,
  input  logic            ack_m1,
  input  logic            ack_iorq,
  input  logic            reti,
  output logic [VW-1:0]   vec_o,
  output logic            vec_vld
);
  localparam int LOWB = 3;

  logic [NSRC-1:0] need, req, svc;
  logic [NSRC-1:0] promote, ack_hit, reti_hit;
  logic [NSRC:0]   en, svc_seen;
  logic [VW-1:LOWB] vbase;
  logic            ack;

  assign ack         = ack_m1 & ack_iorq;
  assign en[0]       = iei;
  assign svc_seen[0] = 1'b0;

  for (genvar i = 0; i < NSRC; i++) begin : g_src
    assign en[i+1]       = en[i] & ~(need[i] | req[i] | svc[i]);
    assign svc_seen[i+1] = svc_seen[i] | svc[i];
    assign promote[i]    = need[i] & en[i];
    assign ack_hit[i]    = ack & req[i] & en[i];
    assign reti_hit[i]   = reti & svc[i] & ~svc_seen[i];

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        need[i] <= 1'b0;
        req[i]  <= 1'b0;
        svc[i]  <= 1'b0;
      end else begin
        need[i] <= (need[i] & ~promote[i]) | (zero_evt[i] & irq_en[i]);
        req[i]  <= (req[i] & ~ack_hit[i]) | promote[i];
        svc[i]  <= (svc[i] & ~reti_hit[i]) | ack_hit[i];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      vbase <= '0;
    else if (wr_en && wr_sel == '0 && !wr_data[0])
      vbase <= wr_data[VW-1:LOWB];
  end

  always_comb begin
    vec_o = '0;
    for (int i = 0; i < NSRC; i++)
      if (ack_hit[i]) vec_o = {vbase, {LOWB{1'b0}}} + VW'(2 * i);
  end

  assign vec_vld = |ack_hit;
  assign int_o   = |req;
  assign ieo     = en[NSRC];

  // R9
  vld_only_on_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vec_vld |-> (ack_m1 && ack_iorq));

  // R1
  vec_even_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vec_vld |-> (vec_o[0] == 1'b0));

  // R4
  promote_raises_int_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|promote) |=> int_o);

  // R6
  chain_closed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!iei) |-> (!ieo));

  // R7
  reti_one_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reti && (|svc) && !vec_vld) |=> ($countones(svc) == $countones($past(svc)) - 1));

  // R5
  ack_enters_service_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vec_vld |=> (|svc));
endmodule

// File: tb/sim_daisy_irq_ctrl.sv
module sim_daisy_irq_ctrl;
  logic clk = 0, rst_n = 0;
  logic [3:0] zero_evt = 0, irq_en = 0;
  logic wr_en = 0;
  logic [1:0] wr_sel = 0;
  logic [7:0] wr_data = 0;
  logic iei = 1, ack_m1 = 0, ack_iorq = 0, reti = 0;
  logic ieo, int_o, vec_vld;
  logic [7:0] vec_o;
  int n_run = 0, n_fail = 0;
  bit done = 0;

  always #5 clk = ~clk;

  daisy_irq_ctrl u0 (.clk, .rst_n, .zero_evt, .irq_en, .wr_en, .wr_sel, .wr_data,
    .iei, .ieo, .int_o, .ack_m1, .ack_iorq, .reti, .vec_o, .vec_vld);

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic wr(input int sel, input int data);
    wr_en = 1; wr_sel = 2'(sel); wr_data = 8'(data); tick(); wr_en = 0;
  endtask

  task automatic evt(input logic [3:0] m);
    zero_evt = m; tick(); zero_evt = 0;
  endtask

  task automatic do_ack(input int exp_vec, input string req);
    ack_m1 = 1; ack_iorq = 1; #1;
    chk(vec_vld === 1'b1, req, int'(vec_vld), 1);
    chk(vec_o === 8'(exp_vec), req, int'(vec_o), exp_vec);
    tick(); ack_m1 = 0; ack_iorq = 0; #1;
    chk(vec_vld === 1'b0 && vec_o === 8'h00, "R9", int'(vec_o), 0);
  endtask

  task automatic do_reti();
    reti = 1; tick(); reti = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    tick(); tick(); rst_n = 1; #1;
    // R8 reset state
    chk(int_o === 0, "R8", int'(int_o), 0);
    chk(ieo === 1, "R8", int'(ieo), 1);
    chk(vec_vld === 0 && vec_o === 0, "R8", int'(vec_o), 0);
    irq_en = 4'hF;
    evt(4'b0100); tick();
    do_ack(4, "R8"); do_reti();

    // R1 R4 R5 R6 sweep over all bases and sources
    for (int b = 0; b < 256; b += 7) begin
      wr(0, b & 8'hFE);
      for (int i = 0; i < 4; i++) begin
        evt(4'(1 << i));
        chk(int_o === 0 && ieo === 0, "R3", int'(int_o), 0);
        tick();
        chk(int_o === 1, "R4", int'(int_o), 1);
        do_ack(((b & 8'hFE) & 8'hF8) + 2 * i, "R1");
        chk(int_o === 0, "R5", int'(int_o), 0);
        chk(ieo === 0, "R6", int'(ieo), 0);
        do_reti();
        chk(ieo === 1, "R7", int'(ieo), 1);
      end
    end

    // R2 ignored writes
    wr(0, 8'h50);
    wr(1, 8'hA0); wr(2, 8'hC0); wr(3, 8'hE0); wr(0, 8'h91);
    for (int i = 0; i < 4; i++) begin
      evt(4'(1 << i)); tick();
      do_ack(8'h50 + 2 * i, "R2");
      do_reti();
    end

    // R3 disabled source ignores pulse
    irq_en = 4'b1101;
    evt(4'b0010); tick(); tick();
    chk(ieo === 1 && int_o === 0, "R3", int'(ieo), 1);
    ack_m1 = 1; ack_iorq = 1; #1;
    chk(vec_vld === 0, "R9", int'(vec_vld), 0);
    ack_m1 = 0; ack_iorq = 0;
    irq_en = 4'hF;

    // R6 chain enable low blocks promotion
    iei = 0;
    evt(4'b0001); tick(); tick();
    chk(int_o === 0 && ieo === 0, "R6", int'(int_o), 0);
    iei = 1; tick();
    chk(int_o === 1, "R6", int'(int_o), 1);
    do_ack(8'h50, "R6"); do_reti();
    chk(ieo === 1, "R6", int'(ieo), 1);

    // R6 simultaneous pulses: source 1 first, then 3
    evt(4'b1010); tick();
    do_ack(8'h52, "R6");
    tick(); tick();
    chk(int_o === 0, "R6", int'(int_o), 0);
    do_reti(); tick();
    chk(int_o === 1, "R6", int'(int_o), 1);
    do_ack(8'h56, "R6"); do_reti();
    chk(ieo === 1, "R6", int'(ieo), 1);

    // R7 nesting: source 2 in service, source 0 nests
    evt(4'b0100); tick(); do_ack(8'h54, "R5");
    evt(4'b0001); tick();
    chk(int_o === 1, "R4", int'(int_o), 1);
    do_ack(8'h50, "R5");
    do_reti();
    chk(ieo === 0, "R7", int'(ieo), 0);
    do_reti();
    chk(ieo === 1, "R7", int'(ieo), 1);

    // R7 reti clears source 2 although source 0 is requested
    evt(4'b0100); tick(); do_ack(8'h54, "R7");
    evt(4'b0001); tick();
    do_reti();
    do_ack(8'h50, "R7");
    do_reti();
    chk(ieo === 1, "R7", int'(ieo), 1);

    // R5 R7 ack and reti in the same cycle
    evt(4'b0100); tick(); do_ack(8'h54, "R5");
    evt(4'b0001); tick();
    reti = 1; ack_m1 = 1; ack_iorq = 1; #1;
    chk(vec_o === 8'h50 && vec_vld === 1, "R5", int'(vec_o), 8'h50);
    tick(); reti = 0; ack_m1 = 0; ack_iorq = 0; #1;
    chk(ieo === 0 && int_o === 0, "R7", int'(ieo), 0);
    do_reti();
    chk(ieo === 1, "R7", int'(ieo), 1);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule